// File: doc/BRIEF.md
# Polled Serial Port With Handshake-Flag Data Register

This block is a bus-attached asynchronous serial port meant for software that polls rather than takes interrupts. It owns one transmit line and one receive line. A byte written by software goes out as an 8N1 frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A frame arriving on the receive line is assembled and parked in a one-entry holding register. The bit rate comes from an external tick strobe, and every bit lasts a fixed number of ticks (16 by default).

Software talks to the block through a plain single-cycle read/write port with 32-bit data and three word registers. The data word holds the byte together with two handshake flags. One flag says the transmitter can take a byte. The other says a received byte is waiting. Setting the transmit flag in a write launches a byte. Writing one to the receive flag consumes the waiting byte. The control word holds an interface-mode field, two ready-override bits and a sticky overrun bit. The clock word is a 32-bit configuration word that software writes and reads back, for use by the external tick generator.

Top module: `pollable_uart`

## Requirements
- R1: Offset 0x0 is the data word: bit 9 reads 1 when the transmitter is idle, bit 8 reads 1 while a received byte is held, and bits [7:0] read the held byte. All other bits read 0. Offset 0x4 is the control word and offset 0x8 is the clock word.
- R2: After reset the data word reads 0x200, the control word reads 0, the clock word reads 0, and txd is high.
- R3: A data-word write with bit 9 set while the transmitter is idle starts a frame on txd on the next clock: a low start bit, bits [7:0] LSB first, then a high stop bit, each 16 ticks long. Bit 9 reads 0 until the frame ends.
- R4: A data-word write with bit 9 set while a frame is in progress has no effect: no extra frame is sent and the current frame is unchanged.
- R5: A complete received frame with a high stop bit, when no byte is held, sets bit 8 of the data word and makes bits [7:0] equal to the received byte.
- R6: A data-word write with bit 8 set clears the received-byte flag. A data-word write with bit 9 clear sends nothing.
- R7: A low pulse on rxd that has ended by mid start bit (8 ticks) is discarded, and no byte is received.
- R8: A frame that completes while a byte is already held is dropped: the held byte stays, and control bit 12 (overrun) becomes 1.
- R9: Control bit 12 stays set until a control write with bit 12 set clears it. A control write with bit 12 clear leaves it set.
- R10: Control bits [3:2] (mode: 1 DTE, 2 DCE), bit 7 (transmit-ready override) and bit 8 (receive-ready override) read back as written, and all other control bits read 0. The clock word reads back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-rate strobe, one clock wide |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| req | input | 1 | Bus access strobe |
| we | input | 1 | Bus write enable |
| addr | input | 4 | Byte address of the register word |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, combinational on addr |

## Verification
The hardest case to reach is the overrun. It needs a whole second frame to finish on rxd while the first byte is still unacknowledged. The bench serialises two bytes back to back without writing the clear flag, then reads the data word to confirm that the first byte survived. It then reads the control word to see the sticky bit, and clears that bit in two steps. The false start is reached by holding rxd low for fewer ticks than half a bit. Writes made while a frame is in progress are placed a few clocks after a frame starts, and the transmit scoreboard would catch any extra or corrupted frame.

// File: rtl/pollable_uart_pkg.sv
package pollable_uart_pkg;
    localparam int BUS_W = 32;

    localparam logic [3:0] OFF_DATA = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_CLK  = 4'h8;

    localparam int DAT_RXV_BIT = 8;
    localparam int DAT_TXR_BIT = 9;

    localparam int CTL_MODE_LO = 2;
    localparam int CTL_MODE_HI = 3;
    localparam int CTL_TXO_BIT = 7;
    localparam int CTL_RXO_BIT = 8;
    localparam int CTL_OVR_BIT = 12;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_phase_e;

    typedef struct packed {
        logic [7:0]       hold;
        logic             rx_full;
        logic             ovr;
        logic [1:0]       mode;
        logic             tx_ovr;
        logic             rx_ovr;
        logic [BUS_W-1:0] clkcfg;
    } reg_state_t;
endpackage

// File: rtl/pollable_uart_tx.sv
module pollable_uart_tx #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] byte_in,
    output logic                 idle,
    output logic                 txd
);
    localparam int FRAME_W = DATA_BITS + 2;
    localparam int TICK_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [TICK_W-1:0]  tcnt;
        logic [CNT_W-1:0]   bcnt;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.frame = {1'b1, byte_in, 1'b0};
                st_d.tcnt  = '0;
                st_d.bcnt  = '0;
            end
        end else if (tick) begin
            if (st_q.tcnt == TICK_W'(TICKS_PER_BIT - 1)) begin
                st_d.tcnt  = '0;
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                if (st_q.bcnt == CNT_W'(FRAME_W - 1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, frame: '1, tcnt: '0, bcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = !st_q.busy;
    assign txd  = st_q.busy ? st_q.frame[0] : 1'b1;
endmodule

// File: rtl/pollable_uart_rx.sv
module pollable_uart_rx
    import pollable_uart_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    output logic                 strobe,
    output logic [DATA_BITS-1:0] byte_out
);
    localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int HALF   = (TICKS_PER_BIT > 1) ? TICKS_PER_BIT / 2 : 1;
    localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        logic                 s1;
        logic                 s2;
        logic                 prev;
        rx_phase_e            phase;
        logic [TICK_W-1:0]    tcnt;
        logic [BIT_W-1:0]     bcnt;
        logic [DATA_BITS-1:0] shreg;
        logic                 strobe;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.s1     = rxd;
        st_d.s2     = st_q.s1;
        st_d.prev   = st_q.s2;
        st_d.strobe = 1'b0;
        case (st_q.phase)
            RX_IDLE: begin
                if (st_q.prev && !st_q.s2) begin
                    st_d.phase = RX_START;
                    st_d.tcnt  = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.tcnt == TICK_W'(HALF - 1)) begin
                        st_d.tcnt = '0;
                        st_d.bcnt = '0;
                        st_d.phase = st_q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (st_q.tcnt == TICK_W'(TICKS_PER_BIT - 1)) begin
                        st_d.tcnt  = '0;
                        st_d.shreg = {st_q.s2, st_q.shreg[DATA_BITS-1:1]};
                        if (st_q.bcnt == BIT_W'(DATA_BITS - 1)) begin
                            st_d.phase = RX_STOP;
                        end else begin
                            st_d.bcnt = st_q.bcnt + 1'b1;
                        end
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (st_q.tcnt == TICK_W'(TICKS_PER_BIT - 1)) begin
                        st_d.tcnt   = '0;
                        st_d.strobe = st_q.s2;
                        st_d.phase  = RX_IDLE;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
            end
            default: st_d.phase = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, phase: RX_IDLE,
                      tcnt: '0, bcnt: '0, shreg: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe   = st_q.strobe;
    assign byte_out = st_q.shreg;
endmodule

// File: rtl/pollable_uart.sv
module pollable_uart
    import pollable_uart_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              txd,
    input  logic              req,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);
    localparam int DATA_BITS = 8;

    logic                 wr_data, wr_ctrl, wr_clk;
    logic                 tx_start, rx_clear;
    logic                 tx_idle;
    logic                 rx_strobe;
    logic [DATA_BITS-1:0] rx_byte;

    reg_state_t st_d, st_q;

    assign wr_data  = req && we && (addr == OFF_DATA);
    assign wr_ctrl  = req && we && (addr == OFF_CTRL);
    assign wr_clk   = req && we && (addr == OFF_CLK);
    assign tx_start = wr_data && wdata[DAT_TXR_BIT];
    assign rx_clear = wr_data && wdata[DAT_RXV_BIT];

    pollable_uart_tx #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .DATA_BITS    (DATA_BITS)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start  (tx_start),
        .byte_in(wdata[DATA_BITS-1:0]),
        .idle   (tx_idle),
        .txd    (txd)
    );

    pollable_uart_rx #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .DATA_BITS    (DATA_BITS)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rxd     (rxd),
        .strobe  (rx_strobe),
        .byte_out(rx_byte)
    );

    always_comb begin
        st_d = st_q;
        if (rx_clear) begin
            st_d.rx_full = 1'b0;
        end
        if (wr_ctrl) begin
            st_d.mode   = wdata[CTL_MODE_HI:CTL_MODE_LO];
            st_d.tx_ovr = wdata[CTL_TXO_BIT];
            st_d.rx_ovr = wdata[CTL_RXO_BIT];
            if (wdata[CTL_OVR_BIT]) begin
                st_d.ovr = 1'b0;
            end
        end
        if (wr_clk) begin
            st_d.clkcfg = wdata;
        end
        if (rx_strobe) begin
            if (st_d.rx_full) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.hold    = rx_byte;
                st_d.rx_full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_DATA: begin
                rdata[DATA_BITS-1:0] = st_q.hold;
                rdata[DAT_RXV_BIT]   = st_q.rx_full;
                rdata[DAT_TXR_BIT]   = tx_idle;
            end
            OFF_CTRL: begin
                rdata[CTL_MODE_HI:CTL_MODE_LO] = st_q.mode;
                rdata[CTL_TXO_BIT]             = st_q.tx_ovr;
                rdata[CTL_RXO_BIT]             = st_q.rx_ovr;
                rdata[CTL_OVR_BIT]             = st_q.ovr;
            end
            OFF_CLK: rdata = st_q.clkcfg;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pollable_uart_checker.sv
module pollable_uart_checker
    import pollable_uart_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             we,
    input logic [3:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic             txd,
    input logic             tx_idle,
    input logic             rx_strobe,
    input logic             rx_full,
    input logic             ovr,
    input logic [7:0]       hold
);
    logic dw, cw;
    assign dw = req && we && (addr == OFF_DATA);
    assign cw = req && we && (addr == OFF_CTRL);

    AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && wdata[DAT_TXR_BIT] && tx_idle) |=> (!tx_idle && !txd)); // R3
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !rx_full) |=> rx_full); // R5
    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && wdata[DAT_RXV_BIT] && !rx_strobe) |=> !rx_full); // R6
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_strobe && !(dw && wdata[DAT_RXV_BIT])) |=> (ovr && $stable(hold))); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(cw && wdata[CTL_OVR_BIT])) |=> ovr); // R9
endmodule

bind pollable_uart pollable_uart_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .txd      (txd),
    .tx_idle  (tx_idle),
    .rx_strobe(rx_strobe),
    .rx_full  (st_q.rx_full),
    .ovr      (st_q.ovr),
    .hold     (st_q.hold)
);

// File: tb/pollable_uart_bench.sv
module pollable_uart_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int TPB        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    pollable_uart #(.TICKS_PER_BIT(TPB)) u_pollable_uart (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .txd(txd),
        .req(req), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
    endtask

    // driver: queue the expected frame, then launch it
    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        bus_write(4'h0, 32'h200 | {24'h0, b});
    endtask

    task automatic wait_tx_idle();
        logic [31:0] v;
        v = '0;
        while (!v[9]) bus_read(4'h0, v);
    endtask

    task automatic drive_rx(input logic [7:0] b);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = fr[i];
            wait_ticks(TPB);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // monitor: decode frames on txd and compare against the queue (R3, R4)
    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd == 1'b0) begin
                wait_ticks(TPB / 2);
                @(negedge clk);
                check(txd == 1'b0, "R3 start bit", {31'h0, txd}, 32'h0);
                for (int i = 0; i < 8; i++) begin
                    wait_ticks(TPB);
                    @(negedge clk);
                    got[i] = txd;
                end
                wait_ticks(TPB);
                @(negedge clk);
                check(txd == 1'b1, "R3 stop bit", {31'h0, txd}, 32'h1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame", {24'h0, got}, 32'h0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, "R3 frame byte", {24'h0, got}, {24'h0, exp});
                end
                while (txd == 1'b0) @(negedge clk);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R2 txd idle high", {31'h0, txd}, 32'h1);
        rst_n = 1'b1;
        bus_read(4'h0, v); check(v == 32'h200, "R2 R1 data word reset", v, 32'h200);
        bus_read(4'h4, v); check(v == 32'h0, "R2 control reset", v, 32'h0);
        bus_read(4'h8, v); check(v == 32'h0, "R2 clock reset", v, 32'h0);

        // R10 field read-back
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, v); check(v == 32'h18C, "R10 control all-ones", v, 32'h18C);
        bus_write(4'h4, 32'h8);
        bus_read(4'h4, v); check(v == 32'h8, "R10 DCE mode", v, 32'h8);
        bus_write(4'h8, 32'h0123_4567);
        bus_read(4'h8, v); check(v == 32'h0123_4567, "R10 clock word", v, 32'h0123_4567);
        bus_write(4'h4, 32'h0);

        // R3 transmit, R4 write while busy ignored
        send_tx(8'hA5);
        bus_read(4'h0, v); check(v[9] == 1'b0, "R3 busy flag", {31'h0, v[9]}, 32'h0);
        repeat (20) @(negedge clk);
        bus_write(4'h0, 32'h23C);
        wait_tx_idle();
        check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 32'h0);
        send_tx(8'h00); wait_tx_idle();
        send_tx(8'hFF); wait_tx_idle();
        send_tx(8'h81); wait_tx_idle();
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 32'h0);

        // R5 receive, R6 clear
        drive_rx(8'h3C);
        bus_read(4'h0, v); check(v == 32'h33C, "R5 received byte", v, 32'h33C);
        bus_write(4'h0, 32'h100);
        bus_read(4'h0, v); check(v[9:8] == 2'b10, "R6 flag cleared", {30'h0, v[9:8]}, 32'h2);
        repeat (700) @(negedge clk);
        check(txd == 1'b1 && exp_q.size() == 0, "R6 no frame from clear", {31'h0, txd}, 32'h1);

        // R7 false start
        @(negedge clk); rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(180);
        bus_read(4'h0, v); check(v[8] == 1'b0, "R7 glitch rejected", {31'h0, v[8]}, 32'h0);

        // R8 overrun
        drive_rx(8'h5A);
        drive_rx(8'hC3);
        bus_read(4'h0, v); check(v == 32'h35A, "R8 held byte kept", v, 32'h35A);
        bus_read(4'h4, v); check(v[12] == 1'b1, "R8 overrun set", {31'h0, v[12]}, 32'h1);

        // R9 sticky, write-one-to-clear
        bus_write(4'h4, 32'h0);
        bus_read(4'h4, v); check(v[12] == 1'b1, "R9 write zero keeps", {31'h0, v[12]}, 32'h1);
        bus_write(4'h4, 32'h1000);
        bus_read(4'h4, v); check(v == 32'h0, "R9 write one clears", v, 32'h0);

        bus_write(4'h0, 32'h100);
        drive_rx(8'hC3);
        bus_read(4'h0, v); check(v == 32'h3C3, "R5 receive after clear", v, 32'h3C3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule